// File: doc/BRIEF.md
# Windowed Instruction Register File

This block keeps a small store of frequently executed instructions, organised as several windows of 32 entries each. A packed fetch word names instructions by a 5-bit slot number. That slot number is always taken relative to the window that is currently selected, so the packed encoding stays the same whichever window is live. The selected window changes on function calls and returns. A call target address carries the wanted window in its two top bits. The block takes the window from there and hands fetch the target with those bits cleared. At the same moment it saves the return address and the outgoing window on an 8-entry hardware stack. A return pops that pair, redirects fetch to the saved address and brings the saved window back.

A loader fills any entry of any window through a separate write port. The read port is registered: a slot number presented in one cycle returns that entry one cycle later, from the window that was current when the read was issued. A one-hot enable vector marks the single live window, so the other windows' read logic and storage can be held in a low-power state. When the stack is full, a further call drops the oldest saved pair and pulses an overflow flag. A return with nothing saved sends fetch to address 0 in window 0.

Top module: `wirf`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, win_o is 0, win_en_o is 4'b0001, rd_data_o is 0, ovf_o is 0, redirect_o is 0 and pc_o is 0.
- R2: In a cycle with call_i high, redirect_o is 1 and pc_o equals call_target_i with bits [31:30] forced to 0, in that same cycle.
- R3: After a call, win_o equals the call's call_target_i[31:30] from the next cycle. In a cycle with neither call_i nor ret_i, win_o does not change.
- R4: A call pushes ret_addr_i together with the window current in the call cycle. In a cycle with ret_i high and call_i low, redirect_o is 1 and pc_o is the most recently pushed return address that has not yet been popped, in that same cycle. From the next cycle win_o is the window that was pushed with it. Pushes and pops follow last-in, first-out order.
- R5: rd_en_i high in cycle N with slot rd_idx_i makes rd_data_o, from cycle N+1, equal the entry at that slot of the window that win_o showed in cycle N. rd_data_o holds its value in every cycle that follows a cycle with rd_en_i low.
- R6: A read issued in the same cycle as a call or return returns data from the window in force before the switch. A read issued in the cycle after the switch uses the new window.
- R7: wr_en_i high writes wr_data_i into slot wr_idx_i of window wr_win_i, whichever window is current. The new value is seen by reads issued from the next cycle on. A read of the same entry in the write cycle returns the old value.
- R8: win_en_o is one-hot, and its set bit is at the position of win_o.
- R9: The stack holds 8 entries. A call made while 8 entries are held makes ovf_o 1 for exactly the next cycle and discards the oldest entry. ovf_o is 0 in every other cycle. The 8 most recent entries remain and are popped in order.
- R10: A return issued while the stack is empty drives pc_o to 0 and sets win_o to 0 from the next cycle.
- R11: When call_i and ret_i are high in the same cycle, the call is carried out and the return is ignored: nothing is popped, and pc_o and the window follow the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call taken this cycle |
| call_target_i | input | 32 | Call target; bits [31:30] select the new window |
| ret_addr_i | input | 32 | Return address saved by a call |
| ret_i | input | 1 | Return taken this cycle |
| redirect_o | output | 1 | Fetch redirect valid (call or return) |
| pc_o | output | 32 | Redirect address for fetch, window bits cleared; 0 when idle |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 5 | Slot number within the current window |
| rd_data_o | output | 32 | Registered read data |
| wr_en_i | input | 1 | Load write enable |
| wr_win_i | input | 2 | Window to write |
| wr_idx_i | input | 5 | Slot to write |
| wr_data_i | input | 32 | Instruction word to write |
| win_o | output | 2 | Current window pointer |
| win_en_o | output | 4 | One-hot enable of the live window |
| ovf_o | output | 1 | One-cycle pulse after a push onto a full stack |

## Verification
The bench goes after the cycle in which the window changes. If a read issued together with a call or return were served from the new window, the returned word would come from the wrong window's entry. It runs nine nested calls. A stack that saturated instead of discarding its oldest entry would restore the wrong return addresses, and a missing or stretched ovf_o pulse would show up directly. Returns on an empty stack must send fetch to 0 in window 0 and not to stale contents. A call and a return in the same cycle must leave the stack holding one more entry, which a design that popped would not. Long random runs mix loads into inactive windows with reads and switches, so a write that went to the current window instead of the addressed one shows up as a read mismatch.

// File: rtl/wirf_pkg.sv
`timescale 1ns/1ps
package wirf_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/wirf_stack.sv
`timescale 1ns/1ps
module wirf_stack
  import wirf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int WW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [WW-1:0] push_win_i,
  output logic [AW-1:0] top_addr_o,
  output logic [WW-1:0] top_win_o,
  output logic          ovf_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] addr_q [DEPTH];
  logic [WW-1:0] win_q  [DEPTH];
  logic [PW-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          empty;

  // circular buffer: a push on a full stack overwrites the oldest entry
  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
  assign empty   = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        win_q[i]  <= '0;
      end
    end else begin
      ovf_q <= 1'b0;
      unique case (op_i)
        STK_PUSH: begin
          addr_q[ptr_q] <= push_addr_i;
          win_q[ptr_q]  <= push_win_i;
          ptr_q         <= ptr_inc;
          if (cnt_q == FULL) ovf_q <= 1'b1;
          else               cnt_q <= cnt_q + 1'b1;
        end
        STK_POP: begin
          if (!empty) begin
            ptr_q <= ptr_dec;
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign top_addr_o = empty ? '0 : addr_q[ptr_dec];
  assign top_win_o  = empty ? '0 : win_q[ptr_dec];
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/wirf_bank.sv
`timescale 1ns/1ps
module wirf_bank #(
  parameter int SLOTS = 32,
  parameter int IW    = 32,
  parameter int XW    = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          wr_en_i,
  input  logic [XW-1:0] wr_idx_i,
  input  logic [IW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [XW-1:0] rd_idx_i,
  output logic [IW-1:0] rd_data_o
);
  logic [IW-1:0] mem_q [SLOTS];
  logic [IW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  // read register toggles only while this window is live
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (rd_en_i && act_i)  rd_q <= mem_q[rd_idx_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/wirf_ctrl.sv
`timescale 1ns/1ps
module wirf_ctrl
  import wirf_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = $clog2(NUM_WIN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic [PC_W-1:0]    call_target_i,
  input  logic [PC_W-1:0]    ret_addr_i,
  input  logic [PC_W-1:0]    top_addr_i,
  input  logic [WIN_W-1:0]   top_win_i,
  output stk_op_e            stk_op_o,
  output logic [PC_W-1:0]    push_addr_o,
  output logic [WIN_W-1:0]   push_win_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [WIN_W-1:0]   win_o,
  output logic [NUM_WIN-1:0] win_en_o
);
  localparam logic [PC_W-1:0] PC_MASK = {{WIN_W{1'b0}}, {(PC_W-WIN_W){1'b1}}};

  logic [WIN_W-1:0] win_q, win_d;

  always_comb begin
    stk_op_o   = STK_IDLE;
    win_d      = win_q;
    pc_o       = '0;
    redirect_o = 1'b0;
    if (call_i) begin
      stk_op_o   = STK_PUSH;
      win_d      = call_target_i[PC_W-1 -: WIN_W];
      pc_o       = call_target_i & PC_MASK;
      redirect_o = 1'b1;
    end else if (ret_i) begin
      stk_op_o   = STK_POP;
      win_d      = top_win_i;
      pc_o       = top_addr_i;
      redirect_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end

  assign push_addr_o = ret_addr_i;
  assign push_win_o  = win_q;
  assign win_o       = win_q;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
    assign win_en_o[g] = (win_q == WIN_W'(g));
  end
endmodule

// File: rtl/wirf.sv
`timescale 1ns/1ps
module wirf
  import wirf_pkg::*;
#(
  parameter int NUM_WIN     = 4,
  parameter int SLOTS       = 32,
  parameter int INSN_W      = 32,
  parameter int PC_W        = 32,
  parameter int STACK_DEPTH = 8,
  localparam int WIN_W      = $clog2(NUM_WIN),
  localparam int IDX_W      = $clog2(SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               call_i,
  input  logic [PC_W-1:0]    call_target_i,
  input  logic [PC_W-1:0]    ret_addr_i,
  input  logic               ret_i,
  output logic               redirect_o,
  output logic [PC_W-1:0]    pc_o,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [INSN_W-1:0]  rd_data_o,
  input  logic               wr_en_i,
  input  logic [WIN_W-1:0]   wr_win_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [INSN_W-1:0]  wr_data_i,
  output logic [WIN_W-1:0]   win_o,
  output logic [NUM_WIN-1:0] win_en_o,
  output logic               ovf_o
);
  stk_op_e           stk_op;
  logic [PC_W-1:0]   push_addr, top_addr;
  logic [WIN_W-1:0]  push_win, top_win;
  logic [WIN_W-1:0]  rd_win_q;
  logic [INSN_W-1:0] bank_rd [NUM_WIN];

  wirf_ctrl #(.PC_W(PC_W), .NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_ctrl (
    .clk_i, .rst_ni, .call_i, .ret_i, .call_target_i, .ret_addr_i,
    .top_addr_i(top_addr), .top_win_i(top_win),
    .stk_op_o(stk_op), .push_addr_o(push_addr), .push_win_o(push_win),
    .redirect_o, .pc_o, .win_o, .win_en_o
  );

  wirf_stack #(.DEPTH(STACK_DEPTH), .AW(PC_W), .WW(WIN_W)) u_stack (
    .clk_i, .rst_ni, .op_i(stk_op),
    .push_addr_i(push_addr), .push_win_i(push_win),
    .top_addr_o(top_addr), .top_win_o(top_win), .ovf_o
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_bank
    wirf_bank #(.SLOTS(SLOTS), .IW(INSN_W), .XW(IDX_W)) u_bank (
      .clk_i, .rst_ni,
      .act_i     (win_en_o[g]),
      .wr_en_i   (wr_en_i && (wr_win_i == WIN_W'(g))),
      .wr_idx_i,
      .wr_data_i,
      .rd_en_i,
      .rd_idx_i,
      .rd_data_o (bank_rd[g])
    );
  end

  // window of the last issued read picks the bank output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_win_q <= '0;
    else if (rd_en_i) rd_win_q <= win_o;
  end

  assign rd_data_o = bank_rd[rd_win_q];
endmodule

// File: rtl/wirf_chk.sv
`timescale 1ns/1ps
module wirf_chk #(
  parameter int PC_W    = 32,
  parameter int NUM_WIN = 4,
  parameter int INSN_W  = 32,
  parameter int WIN_W   = $clog2(NUM_WIN)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               call_i,
  input logic               ret_i,
  input logic [PC_W-1:0]    call_target_i,
  input logic               redirect_o,
  input logic [PC_W-1:0]    pc_o,
  input logic [WIN_W-1:0]   win_o,
  input logic [NUM_WIN-1:0] win_en_o,
  input logic               rd_en_i,
  input logic [INSN_W-1:0]  rd_data_o,
  input logic               ovf_o
);
  AST_CALL_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |-> (redirect_o && pc_o[PC_W-1 -: WIN_W] == '0)); // R2
  AST_CALL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> (win_o == $past(call_target_i[PC_W-1 -: WIN_W]))); // R3
  AST_IDLE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && !ret_i) |=> $stable(win_o)); // R3
  AST_RET_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i) |-> redirect_o); // R4
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && !ret_i) |-> (!redirect_o && pc_o == '0)); // R4
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R5
  AST_ENABLE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(win_en_o) == 1) && win_en_o[win_o]); // R8
  AST_OVF_AFTER_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(call_i)); // R9
  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !call_i) |=> !ovf_o); // R9
endmodule

bind wirf wirf_chk #(.PC_W(PC_W), .NUM_WIN(NUM_WIN), .INSN_W(INSN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
  .call_target_i(call_target_i), .redirect_o(redirect_o), .pc_o(pc_o),
  .win_o(win_o), .win_en_o(win_en_o), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .ovf_o(ovf_o)
);

// File: tb/wirf_test.sv
`timescale 1ns/1ps
module wirf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call = 1'b0, ret = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] tgt = '0, raddr = '0, wdata = '0;
  logic [4:0]  rd_idx = '0, wr_idx = '0;
  logic [1:0]  wr_win = '0;
  logic        redirect, ovf;
  logic [31:0] pc, rd_data;
  logic [1:0]  win;
  logic [3:0]  win_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_mem [4][32];
  logic [31:0] m_sa [8];
  logic [1:0]  m_sw [8];
  int          m_cnt = 0;
  logic [1:0]  m_win = '0;
  logic [31:0] m_rd = '0;
  logic        m_ovf = 1'b0;

  always #4 clk = ~clk;

  wirf uut (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .call_target_i(tgt),
    .ret_addr_i(raddr), .ret_i(ret), .redirect_o(redirect), .pc_o(pc),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_win_i(wr_win), .wr_idx_i(wr_idx), .wr_data_i(wdata),
    .win_o(win), .win_en_o(win_en), .ovf_o(ovf)
  );

  task automatic chk(string ctx, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%h expected=%h", ctx, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pc();
    if (call) return {2'b00, tgt[29:0]};
    if (ret)  return (m_cnt > 0) ? m_sa[m_cnt-1] : 32'h0;
    return 32'h0;
  endfunction

  task automatic model_edge();
    if (rd_en) m_rd = m_mem[m_win][rd_idx];
    if (wr_en) m_mem[wr_win][wr_idx] = wdata;
    m_ovf = 1'b0;
    if (call) begin
      if (m_cnt == 8) begin
        for (int i = 0; i < 7; i++) begin
          m_sa[i] = m_sa[i+1];
          m_sw[i] = m_sw[i+1];
        end
        m_cnt = 7;
        m_ovf = 1'b1;
      end
      m_sa[m_cnt] = raddr;
      m_sw[m_cnt] = m_win;
      m_cnt++;
      m_win = tgt[31:30];
    end else if (ret) begin
      if (m_cnt > 0) begin
        m_cnt--;
        m_win = m_sw[m_cnt];
      end else begin
        m_win = 2'd0;
      end
    end
  endtask

  // inputs are already set; checks combinational then registered outputs
  task automatic step(string ctx);
    #1;
    chk(ctx, "R2/R4 redirect", {31'd0, redirect}, {31'd0, call | ret});
    chk(ctx, "R2/R4/R10 pc", pc, exp_pc());
    @(posedge clk);
    model_edge();
    #1;
    chk(ctx, "R3 win", {30'd0, win}, {30'd0, m_win});
    chk(ctx, "R8 win_en", {28'd0, win_en}, {28'd0, 4'b0001 << m_win});
    chk(ctx, "R5 rd_data", rd_data, m_rd);
    chk(ctx, "R9 ovf", {31'd0, ovf}, {31'd0, m_ovf});
    call = 0; ret = 0; rd_en = 0; wr_en = 0;
  endtask

  initial begin
    void'($urandom(32'd20061023));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "R1 win", {30'd0, win}, 32'd0);
    chk("R1", "R1 win_en", {28'd0, win_en}, 32'd1);
    chk("R1", "R1 rd_data", rd_data, 32'd0);
    chk("R1", "R1 ovf", {31'd0, ovf}, 32'd0);
    chk("R1", "R1 redirect", {31'd0, redirect}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "R1 win after release", {30'd0, win}, 32'd0);

    // return on empty stack
    ret = 1; step("R10 empty pop");

    // load every entry of every window
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 32; i++) begin
        wr_en = 1; wr_win = 2'(w); wr_idx = 5'(i); wdata = $urandom;
        step("R7 load");
      end

    // read in the switch cycle uses the old window, the next read the new one
    rd_en = 1; rd_idx = 5'd5; call = 1; tgt = 32'h8000_1234; raddr = 32'h0000_0100;
    step("R6 read with call");
    rd_en = 1; rd_idx = 5'd5; step("R6 read after call");
    rd_en = 1; rd_idx = 5'd9; ret = 1; step("R6 read with return");
    rd_en = 1; rd_idx = 5'd9; step("R6 read after return");

    // write then read the same entry of an inactive window
    wr_en = 1; wr_win = 2'd3; wr_idx = 5'd7; wdata = 32'hCAFE_0007; step("R7 inactive write");
    call = 1; tgt = 32'hC000_0040; raddr = 32'h0000_0200; step("R7 switch");
    rd_en = 1; rd_idx = 5'd7; wr_en = 1; wr_win = 2'd3; wr_idx = 5'd7; wdata = 32'h1111_2222;
    step("R7 read during write");
    rd_en = 1; rd_idx = 5'd7; step("R7 read after write");
    step("R5 hold");
    ret = 1; step("R4 unwind");

    // nine nested calls overflow the 8-entry stack, then unwind past empty
    for (int k = 0; k < 9; k++) begin
      call = 1; tgt = {2'(k + 1), 30'(k * 16 + 3)}; raddr = 32'h1000 + 32'(k * 4);
      step("R9 nested call");
    end
    for (int k = 0; k < 10; k++) begin
      ret = 1; step("R4 LIFO pop");
    end

    // call and return together
    call = 1; tgt = 32'h4000_0010; raddr = 32'h0000_0AAA; step("R4 setup");
    call = 1; ret = 1; tgt = 32'hC000_0020; raddr = 32'h0000_0BBB; step("R11 both");
    ret = 1; step("R11 pop newest");
    ret = 1; step("R11 pop older");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      call  = (r < 18);
      ret   = (r >= 15 && r < 35);
      tgt   = $urandom;
      raddr = $urandom;
      rd_en = ($urandom % 100) < 60;
      rd_idx = 5'($urandom);
      wr_en = ($urandom % 100) < 30;
      wr_win = 2'($urandom);
      wr_idx = 5'($urandom);
      wdata = $urandom;
      step("R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL [watchdog] R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule